// File: doc/BRIEF.md
# Occupancy-Tracked Circular Receive Buffer

This block is a byte-wide first-in first-out store meant to sit behind a serial receiver. A byte comes in with `push_valid` and leaves when `pop_req` is raised. The depth is a parameter and defaults to 260 entries, which is not a power of two.

No read pointer is stored. The state is an insert position and a count of the bytes currently held. A push writes at the insert position, moves that position forward modulo the depth and raises the count. A pop reads the slot that lies `count` entries behind the insert position. When that subtraction goes negative, the depth is added back to it. The popped byte comes out through a register one cycle after the request is accepted.

Reset is asserted asynchronously and released through a two-stage synchronizer on `clk`.

Top module: `rxb_circ_buffer`

## Requirements
- R1: While reset is asserted and after it is released, `count` is 0, `empty` is 1, `full` is 0 and `pop_valid` is 0.
- R2: A push (`push_valid`=1) with `count` below DEPTH stores `push_data` and raises `count` by one at the next clock edge.
- R3: A push while `count` equals DEPTH is refused. `count` stays at DEPTH and the byte is never returned by a later pop.
- R4: A pop (`pop_req`=1) with `count` above zero sets `pop_valid`=1 for one cycle after the edge, with `pop_data` holding the oldest stored byte, and lowers `count` by one.
- R5: A pop while `count` is 0 returns nothing: `pop_valid` stays 0 after the edge and `count` stays 0.
- R6: A push and a pop accepted in the same cycle leave `count` unchanged. The pop returns the oldest byte and the pushed byte is appended.
- R7: Bytes come out in arrival order across any number of wrap-arounds of the non-power-of-two index range.
- R8: `empty` is 1 exactly when `count` is 0, and `full` is 1 exactly when `count` equals DEPTH.
- R9: A push and a pop in the same cycle while empty: the push is taken, the pop is refused (`pop_valid`=0) and `count` becomes 1.
- R10: A push and a pop in the same cycle while full: the pop is taken, the push is refused and `count` becomes DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Offer a byte for storage |
| push_data | input | WIDTH | Byte to store |
| pop_req | input | 1 | Request the oldest byte |
| pop_valid | output | 1 | `pop_data` holds a popped byte this cycle |
| pop_data | output | WIDTH | Popped byte, registered |
| count | output | CW | Number of bytes held, CW = clog2(DEPTH+1) |
| empty | output | 1 | Count is zero |
| full | output | 1 | Count equals DEPTH |

## Verification
The bench builds the buffer with its default parameters, DEPTH=260 and WIDTH=8. This keeps the non-power-of-two wrap correction live: the read index goes negative and has to be corrected on every lap. Filling all 260 slots makes the full boundary and the refused-push cases reachable. A long random push/pop run against a queue model carries the insert position around the ring many times, at occupancies from empty to full.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  typedef enum logic [1:0] {
    OCC_HOLD = 2'd0,
    OCC_INC  = 2'd1,
    OCC_DEC  = 2'd2
  } occ_op_e;

endpackage

// File: rtl/rxb_reset_sync.sv
module rxb_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/rxb_occupancy.sv
module rxb_occupancy
  import rxb_pkg::*;
#(
  parameter int DEPTH = 260,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_ok,
  input  logic          pop_ok,
  output logic [CW-1:0] cnt,
  output logic          empty,
  output logic          full
);

  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  occ_op_e       op;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    unique case ({push_ok, pop_ok})
      2'b10:   op = OCC_INC;
      2'b01:   op = OCC_DEC;
      default: op = OCC_HOLD;
    endcase
  end

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (op)
      OCC_INC: begin
        cnt_d  = cnt_q + 1'b1;
        cnt_en = 1'b1;
      end
      OCC_DEC: begin
        cnt_d  = cnt_q - 1'b1;
        cnt_en = 1'b1;
      end
      default: begin
        cnt_d  = cnt_q;
        cnt_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt   = cnt_q;
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_MAX);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX) else $error("count above depth"); // R3

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({empty, full})) else $error("empty and full together"); // R8

  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> $stable(cnt_q)) else $error("count moved on push+pop"); // R6

endmodule

// File: rtl/rxb_index.sv
module rxb_index #(
  parameter int DEPTH = 260,
  parameter int IW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic [CW-1:0] cnt,
  output logic [IW-1:0] wr_idx,
  output logic [IW-1:0] rd_idx
);

  localparam int            SW        = CW + 1;
  localparam logic [IW-1:0] LAST_SLOT = IW'(DEPTH - 1);
  localparam logic [SW-1:0] DEPTH_S   = SW'(DEPTH);

  logic [IW-1:0] ins_q;
  logic [IW-1:0] ins_d;
  logic [SW-1:0] diff;
  logic [SW-1:0] wrapped;

  always_comb begin
    if (ins_q == LAST_SLOT) ins_d = '0;
    else                    ins_d = ins_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ins_q <= '0;
    else if (advance) ins_q <= ins_d;
  end

  // read slot = insert position - count, corrected by DEPTH when negative
  always_comb begin
    diff = {{(SW - IW){1'b0}}, ins_q} - {1'b0, cnt};
    if (diff[SW-1]) wrapped = diff + DEPTH_S;
    else            wrapped = diff;
  end

  assign wr_idx = ins_q;
  assign rd_idx = IW'(wrapped);

  AST_INS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ins_q <= LAST_SLOT) else $error("insert position out of range"); // R7

  AST_RD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wrapped < DEPTH_S) else $error("read index out of range"); // R7

endmodule

// File: rtl/rxb_store.sv
module rxb_store #(
  parameter int DEPTH = 260,
  parameter int WIDTH = 8,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IW-1:0]    wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             re,
  input  logic [IW-1:0]    rd_idx,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rd_data_q;
  logic             rd_valid_q;

  always_ff @(posedge clk) begin
    if (we) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid_q <= 1'b0;
    else        rd_valid_q <= re;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rd_data_q <= '0;
    else if (re) rd_data_q <= mem[rd_idx];
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

  AST_NO_SAME_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (we && re) |-> (wr_idx != rd_idx)) else $error("read and write collide"); // R6

endmodule

// File: rtl/rxb_circ_buffer.sv
module rxb_circ_buffer #(
  parameter int DEPTH = 260,
  parameter int WIDTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_req,
  output logic             pop_valid,
  output logic [WIDTH-1:0] pop_data,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full
);

  localparam int IW = $clog2(DEPTH);

  logic          rst_n_s;
  logic          push_ok;
  logic          pop_ok;
  logic [IW-1:0] wr_idx;
  logic [IW-1:0] rd_idx;

  rxb_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign push_ok = push_valid && !full;
  assign pop_ok  = pop_req && !empty;

  rxb_occupancy #(.DEPTH(DEPTH), .CW(CW)) u_occ (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .push_ok (push_ok),
    .pop_ok  (pop_ok),
    .cnt     (count),
    .empty   (empty),
    .full    (full)
  );

  rxb_index #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_idx (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .advance (push_ok),
    .cnt     (count),
    .wr_idx  (wr_idx),
    .rd_idx  (rd_idx)
  );

  rxb_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .IW(IW)) u_mem (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .we       (push_ok),
    .wr_idx   (wr_idx),
    .wr_data  (push_data),
    .re       (pop_ok),
    .rd_idx   (rd_idx),
    .rd_valid (pop_valid),
    .rd_data  (pop_data)
  );

  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pop_req && empty) |=> !pop_valid) else $error("pop served while empty"); // R5

  AST_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n_s)
    (push_valid && full && !pop_req) |=> (full && $stable(count))) else $error("push taken while full"); // R3

  AST_PUSH_GROW: assert property (@(posedge clk) disable iff (!rst_n_s)
    (push_valid && !full && !pop_req) |=> (count == $past(count) + 1'b1)) else $error("push did not grow count"); // R2

  AST_POP_SHRINK: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pop_req && !empty && !push_valid) |=> (pop_valid && count == $past(count) - 1'b1)) else $error("pop did not shrink count"); // R4

endmodule

// File: tb/tb_rxb_circ_buffer.sv
module tb_rxb_circ_buffer;

  localparam int DEPTH = 260;
  localparam int WIDTH = 8;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int NVEC  = 9;
  localparam int VW    = 1 + 1 + 8 + 1 + 8 + CW;

  // {push, pop, push_data, exp_valid, exp_data, exp_count}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 8'hA1, 1'b0, 8'h00, CW'(1)},  // R2
    {1'b1, 1'b0, 8'hB2, 1'b0, 8'h00, CW'(2)},  // R2
    {1'b0, 1'b1, 8'h00, 1'b1, 8'hA1, CW'(1)},  // R4
    {1'b1, 1'b1, 8'hC3, 1'b1, 8'hB2, CW'(1)},  // R6
    {1'b0, 1'b1, 8'h00, 1'b1, 8'hC3, CW'(0)},  // R4
    {1'b0, 1'b1, 8'h00, 1'b0, 8'h00, CW'(0)},  // R5
    {1'b1, 1'b1, 8'hD4, 1'b0, 8'h00, CW'(1)},  // R9
    {1'b0, 1'b0, 8'h00, 1'b0, 8'h00, CW'(1)},  // R5 idle
    {1'b0, 1'b1, 8'h00, 1'b1, 8'hD4, CW'(0)}   // R4
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             push_valid;
  logic [WIDTH-1:0] push_data;
  logic             pop_req;
  logic             pop_valid;
  logic [WIDTH-1:0] pop_data;
  logic [CW-1:0]    count;
  logic             empty;
  logic             full;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [WIDTH-1:0] model [$];

  always #2 clk = ~clk;

  rxb_circ_buffer #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .push_data  (push_data),
    .pop_req    (pop_req),
    .pop_valid  (pop_valid),
    .pop_data   (pop_data),
    .count      (count),
    .empty      (empty),
    .full       (full)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at negedge, clock once, sample at following negedge
  task automatic cycle(input logic pu, input logic po, input logic [WIDTH-1:0] d);
    push_valid = pu;
    pop_req    = po;
    push_data  = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  // model-checked cycle
  task automatic mcycle(input logic pu, input logic po, input logic [WIDTH-1:0] d, input string req);
    bit pop_acc;
    bit push_acc;
    logic [WIDTH-1:0] expd;
    pop_acc  = po && (model.size() > 0);
    push_acc = pu && (model.size() < DEPTH);
    expd     = '0;
    if (pop_acc) expd = model.pop_front();
    if (push_acc) model.push_back(d);
    cycle(pu, po, d);
    check({req, " valid"}, int'(pop_valid), int'(pop_acc));
    if (pop_acc) check({req, " data"}, int'(pop_data), int'(expd));
    check({req, " count"}, int'(count), model.size());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    push_valid = 1'b0;
    pop_req = 1'b0;
    push_data = '0;
    repeat (3) @(negedge clk);
    check("R1 count", int'(count), 0);
    check("R1 empty", int'(empty), 1);
    check("R1 full", int'(full), 0);
    check("R1 pop_valid", int'(pop_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 count after release", int'(count), 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      cycle(v[VW-1], v[VW-2], v[VW-3 -: 8]);
      check("R4/R5/R6/R9 vec valid", int'(pop_valid), int'(v[CW+8]));
      if (v[CW+8]) check("R4/R6 vec data", int'(pop_data), int'(v[CW+7 -: 8]));
      check("R2/R5/R9 vec count", int'(count), int'(v[CW-1:0]));
      check("R8 vec empty", int'(empty), int'(v[CW-1:0] == 0));
    end

    // fill to full
    for (int i = 0; i < DEPTH; i++) mcycle(1'b1, 1'b0, 8'(i * 7 + 3), "R2 fill");
    check("R8 full", int'(full), 1);
    check("R8 not empty", int'(empty), 0);
    mcycle(1'b1, 1'b0, 8'hEE, "R3 refused push");
    check("R3 still full", int'(full), 1);
    mcycle(1'b1, 1'b1, 8'hEF, "R10 push+pop full");
    check("R10 count", int'(count), DEPTH - 1);
    // drain: refused bytes must never appear
    for (int i = 0; i < DEPTH - 1; i++) mcycle(1'b0, 1'b1, 8'h00, "R3/R4 drain");
    check("R8 empty after drain", int'(empty), 1);

    // long random run, many laps of the ring
    for (int i = 0; i < 30000; i++) begin
      int r;
      logic pu;
      logic po;
      r  = $urandom_range(0, 99);
      pu = (i % 4000 < 2000) ? (r < 65) : (r < 35);
      po = ($urandom_range(0, 99) < 50);
      mcycle(pu, po, 8'($urandom), "R7 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule